// File: doc/BRIEF.md
# Serial EEPROM status register and write-permission guard

This block keeps the status byte of a serial EEPROM and decides, every time the command decoder asks, whether a write may proceed. It holds the write-enable latch, two address-span protect bits and a lock-enable bit that arms the external write-protect pin. The command decoder sends it single-cycle strobes: latch set, latch clear, status-write request with its data byte, and a commit strobe that marks the end of the select phase. The array controller queries it with an address and gets back a registered permit.

The status byte sits in a register and is ready for the read-status command. While the array controller reports an internal write cycle as running, the byte reads all ones. A status write waits between its request and its commit. If the write-protect pin drops during that window while the lock-enable bit is set, the pending write is dropped. The nonvolatile bits are modelled as ordinary flip-flops.

Top module: `eeprom_guard`

## Requirements
- R1: After synchronous reset, status_q is 8'h00, arr_ok is 0 and sr_ok is 0.
- R2: When idle, status_q has the lock-enable bit at bit 7, zeros at bits 6..4, span code at bits 3..2, the write-enable latch at bit 1 and 0 at bit 0. It is registered one cycle behind the state.
- R3: In the cycle after busy_i is seen high, status_q reads 8'hFF.
- R4: wen_set sets the latch only while busy_i is low. wen_clr clears it whatever the level of wp_level and wins over wen_set. The latch also clears in the cycle after busy_i falls.
- R5: Span code 2'b00 protects nothing, 2'b01 protects addresses whose top two bits are 11, 2'b10 protects addresses whose top bit is 1, and 2'b11 protects every address. arr_ok answers arr_req one cycle later.
- R6: arr_ok is 1 only when the latch is set, busy_i is low and the address is unprotected. wp_level plays no part in it.
- R7: A status write is sr_req with sr_data, followed later by sr_go. It is accepted only if the latch is set and busy_i is low at request time. On commit, bit 7 of sr_data loads lock-enable and bits 3..2 load the span code. Other data bits are ignored. sr_ok pulses the cycle after an accepted commit.
- R8: The hardware lock is active when wp_level is 0 and lock-enable is 1. While it is active, a status write is refused at request and at commit. With lock-enable at 0, a low wp_level does not block.
- R9: A cycle with the hardware lock active between request and commit cancels the pending write. wp_level changing after the commit leaves the stored bits unchanged.
- R10: sr_req is ignored without the latch set or while busy_i is high. No sr_ok follows and the stored bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_level | input | 1 | Write-protect pin level, 0 = asserted |
| busy_i | input | 1 | Internal write cycle in progress |
| wen_set | input | 1 | Set write-enable latch strobe |
| wen_clr | input | 1 | Clear write-enable latch strobe |
| sr_req | input | 1 | Status-write request strobe |
| sr_data | input | 8 | Status-write data byte |
| sr_go | input | 1 | Commit strobe (end of select) |
| arr_req | input | 1 | Array write permission query |
| arr_addr | input | ADDR_W | Address of the array write |
| status_q | output | 8 | Registered status byte |
| arr_ok | output | 1 | Registered array write permit |
| sr_ok | output | 1 | Registered status-write commit pulse |

## Verification
The hardest case to reach is a pending status write cancelled by a brief drop of the protect pin. It needs the lock-enable bit already set, a request made while the pin is high, and a single-cycle low pulse that is gone again before the commit. Only then does the refusal come from the cancellation and not from the commit-time check. The stimulus first commits a byte that sets lock-enable, issues a new request, pulses wp_level low for one cycle, and then commits. It also shows that a pin drop after the commit leaves the stored bits unchanged.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef enum logic [1:0] {
    SPAN_NONE    = 2'b00,
    SPAN_QUARTER = 2'b01,
    SPAN_HALF    = 2'b10,
    SPAN_ALL     = 2'b11
  } span_e;

  localparam int SB_LOCK    = 7;
  localparam int SB_SPAN_HI = 3;
  localparam int SB_SPAN_LO = 2;
  localparam int SB_WEL     = 1;
  localparam int SB_BUSY    = 0;
  localparam int SB_W       = 8;
endpackage

// File: rtl/eg_wel.sv
module eg_wel (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  output logic wel_q
);
  logic busy_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_d <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      busy_d <= busy;
      if (clr_req || (busy_d && !busy))
        wel_q <= 1'b0;
      else if (set_req && !busy)
        wel_q <= 1'b1;
    end
  end

  p_clr_wins_r4: assert property (@(posedge clk) disable iff (rst)
    $past(clr_req) && !$past(rst) |-> !wel_q);
  p_set_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_q) |-> !$past(busy));
endmodule

// File: rtl/eg_srwr.sv
module eg_srwr
  import eg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            wel,
  input  logic            wp_level,
  input  logic            req,
  input  logic [SB_W-1:0] data,
  input  logic            go,
  output logic            lock_q,
  output span_e           span_q,
  output logic            hw_lock,
  output logic            done_q
);
  logic            pend_q;
  logic [SB_W-1:0] pend_data;

  assign hw_lock = !wp_level && lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      pend_data <= '0;
      lock_q    <= 1'b0;
      span_q    <= SPAN_NONE;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        if (pend_q && !hw_lock) begin
          lock_q <= pend_data[SB_LOCK];
          span_q <= span_e'(pend_data[SB_SPAN_HI:SB_SPAN_LO]);
          done_q <= 1'b1;
        end
        pend_q <= 1'b0;
      end else if (pend_q && hw_lock) begin
        pend_q <= 1'b0;
      end else if (req && wel && !busy && !hw_lock) begin
        pend_q    <= 1'b1;
        pend_data <= data;
      end
    end
  end

  p_hw_block_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !$past(hw_lock));
  p_commit_after_go_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(go));
  p_hold_without_commit_r9: assert property (@(posedge clk) disable iff (rst)
    !done_q && !$past(rst) |-> $stable(lock_q) && $stable(span_q));
endmodule

// File: rtl/eg_span.sv
module eg_span
  import eg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  span_e             span,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  localparam int TOP = ADDR_W - 1;

  logic top1, top2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top1 = addr[TOP];
      assign top2 = addr[TOP] && addr[TOP-1];
    end else begin : g_narrow
      assign top1 = addr[0];
      assign top2 = addr[0];
    end
  endgenerate

  always_comb begin
    case (span)
      SPAN_QUARTER: blocked = top2;
      SPAN_HALF:    blocked = top1;
      SPAN_ALL:     blocked = 1'b1;
      default:      blocked = 1'b0;
    endcase
  end
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_level,
  input  logic              busy_i,
  input  logic              wen_set,
  input  logic              wen_clr,
  input  logic              sr_req,
  input  logic [7:0]        sr_data,
  input  logic              sr_go,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        status_q,
  output logic              arr_ok,
  output logic              sr_ok
);
  logic  wel;
  logic  lock;
  span_e span;
  logic  hw_lock;
  logic  blocked;
  logic  done;

  eg_wel u_wel (
    .clk(clk), .rst(rst), .busy(busy_i),
    .set_req(wen_set), .clr_req(wen_clr), .wel_q(wel)
  );

  eg_srwr u_srwr (
    .clk(clk), .rst(rst), .busy(busy_i), .wel(wel), .wp_level(wp_level),
    .req(sr_req), .data(sr_data), .go(sr_go),
    .lock_q(lock), .span_q(span), .hw_lock(hw_lock), .done_q(done)
  );

  eg_span #(.ADDR_W(ADDR_W)) u_span (
    .span(span), .addr(arr_addr), .blocked(blocked)
  );

  logic [SB_W-1:0] idle_byte;
  always_comb begin
    idle_byte = '0;
    idle_byte[SB_LOCK] = lock;
    idle_byte[SB_SPAN_HI:SB_SPAN_LO] = span;
    idle_byte[SB_WEL] = wel;
    idle_byte[SB_BUSY] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      arr_ok   <= 1'b0;
    end else begin
      status_q <= busy_i ? '1 : idle_byte;
      arr_ok   <= arr_req && wel && !busy_i && !blocked;
    end
  end

  assign sr_ok = done;

  p_busy_ff_r3: assert property (@(posedge clk) disable iff (rst)
    $past(busy_i) && !$past(rst) |-> status_q == 8'hFF);
  p_spare_zero_r2: assert property (@(posedge clk) disable iff (rst)
    status_q[6:4] != 3'b000 |-> status_q == 8'hFF);
  p_arr_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
    arr_ok |-> $past(wel) && !$past(busy_i));
  p_all_span_r5: assert property (@(posedge clk) disable iff (rst)
    arr_ok |-> $past(span) != SPAN_ALL);
endmodule

// File: tb/eeprom_guard_bench.sv
module eeprom_guard_bench;
  localparam int AW = 16;
  localparam int K_STAT = 0, K_ARR = 1, K_SR = 2;

  logic clk = 0, rst = 1;
  logic wp_level = 1, busy_i = 0, wen_set = 0, wen_clr = 0;
  logic sr_req = 0, sr_go = 0, arr_req = 0;
  logic [7:0] sr_data = 0;
  logic [AW-1:0] arr_addr = 0;
  logic [7:0] status_q;
  logic arr_ok, sr_ok;

  always #4 clk = ~clk;

  eeprom_guard #(.ADDR_W(AW)) u_eeprom_guard (
    .clk(clk), .rst(rst), .wp_level(wp_level), .busy_i(busy_i),
    .wen_set(wen_set), .wen_clr(wen_clr), .sr_req(sr_req), .sr_data(sr_data),
    .sr_go(sr_go), .arr_req(arr_req), .arr_addr(arr_addr),
    .status_q(status_q), .arr_ok(arr_ok), .sr_ok(sr_ok)
  );

  typedef struct { int due; int kind; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = (it.kind == K_STAT) ? status_q :
              (it.kind == K_ARR) ? {7'b0, arr_ok} : {7'b0, sr_ok};
        checks++;
        if (it.due != cyc || act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wen_set = 0; wen_clr = 0; sr_req = 0; sr_go = 0; arr_req = 0;
    end
  endtask

  task automatic chk_stat(logic [7:0] exp, string tag);
    idle(2);
    push(K_STAT, exp, tag);
    idle(1);
  endtask

  task automatic wen(bit set);
    @(negedge clk);
    if (set) wen_set = 1; else wen_clr = 1;
    idle(1);
  endtask

  task automatic arr(logic [AW-1:0] a, logic exp, string tag);
    @(negedge clk);
    arr_req = 1; arr_addr = a;
    push(K_ARR, {7'b0, exp}, tag);
    idle(1);
  endtask

  task automatic swr(logic [7:0] d, logic exp, string tag);
    @(negedge clk);
    sr_req = 1; sr_data = d;
    @(negedge clk);
    sr_req = 0; sr_go = 1;
    push(K_SR, {7'b0, exp}, tag);
    idle(1);
  endtask

  task automatic busy_pulse(int n);
    @(negedge clk); busy_i = 1;
    idle(n);
    @(negedge clk); busy_i = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    push(K_STAT, 8'h00, "R1 status in reset");
    push(K_ARR, 8'h00, "R1 arr_ok in reset");
    push(K_SR, 8'h00, "R1 sr_ok in reset");
    idle(1);
    @(negedge clk); rst = 0;
    chk_stat(8'h00, "R1 status after reset");
    arr(16'h0000, 0, "R6 no latch no permit");
    wen(1);
    chk_stat(8'h02, "R2 R4 latch shown at bit1");
    arr(16'h1234, 1, "R5 span none permits");
    swr(8'h74, 1, "R7 commit accepted");
    chk_stat(8'h06, "R7 spare data bits ignored");
    @(negedge clk); busy_i = 1;
    chk_stat(8'hFF, "R3 busy reads all ones");
    arr(16'h0000, 0, "R6 no permit while busy");
    @(negedge clk); busy_i = 0;
    chk_stat(8'h04, "R4 latch cleared at busy end");
    wen(1);
    arr(16'hC000, 0, "R5 quarter protects C000");
    arr(16'hBFFF, 1, "R5 quarter allows BFFF");
    swr(8'h88, 1, "R7 lock and half");
    chk_stat(8'h8A, "R2 lock bit7 span bits");
    arr(16'h8000, 0, "R5 half protects 8000");
    arr(16'h7FFF, 1, "R5 half allows 7FFF");
    @(negedge clk); wp_level = 0;
    arr(16'h7FFF, 1, "R6 pin does not affect array");
    swr(8'h00, 0, "R8 hw lock refuses");
    chk_stat(8'h8A, "R8 bits unchanged");
    wen(0);
    chk_stat(8'h88, "R4 clear with pin low");
    @(negedge clk); wp_level = 1;
    wen(1);
    chk_stat(8'h8A, "R4 latch set again");
    @(negedge clk); sr_req = 1; sr_data = 8'h80;
    @(negedge clk); sr_req = 0; wp_level = 0;
    @(negedge clk); wp_level = 1;
    @(negedge clk); sr_go = 1;
    push(K_SR, 8'h00, "R9 pin pulse cancels pending");
    idle(1);
    chk_stat(8'h8A, "R9 cancelled write left bits");
    swr(8'h80, 1, "R9 write before pin drop");
    @(negedge clk); wp_level = 0;
    chk_stat(8'h82, "R9 pin drop after commit");
    busy_pulse(3);
    chk_stat(8'h80, "R9 bits after cycle");
    @(negedge clk); wp_level = 1;
    wen(1);
    swr(8'h0C, 1, "R7 full span write");
    chk_stat(8'h0E, "R2 full span read back");
    arr(16'h0000, 0, "R5 full span protects all");
    @(negedge clk); wp_level = 0;
    swr(8'h08, 1, "R8 lock-enable off ignores pin");
    chk_stat(8'h0A, "R8 write landed");
    wen(0);
    swr(8'h00, 0, "R10 no latch refuses");
    chk_stat(8'h08, "R10 bits unchanged");
    wen(1);
    @(negedge clk); busy_i = 1;
    swr(8'h00, 0, "R10 busy refuses");
    @(negedge clk); wen_set = 1;
    idle(1);
    @(negedge clk); busy_i = 0;
    chk_stat(8'h08, "R10 R4 bits and latch after busy");
    idle(4);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items actual=%0d expected=0", sb.size(), sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule